// File: doc/BRIEF.md
# Centre-Aligned Dual-Channel PWM Timer

This block is a 16-bit timer whose counter climbs from zero to a programmable peak and then falls back to zero, over and over. Two compare channels compare their thresholds against this triangle and drive PWM pins whose pulses are centred on the zero point of the count. The pulse centres do not drift, so the waveform suits motor drives and other loads that need symmetric switching edges. The peak comes either from a dedicated period register or from channel A's threshold. A prescaler divides the input clock by 1, 8, 64, 256 or 1024 to form the timer tick, or holds the timer still.

Software writes the period and the thresholds into shadow registers. The timer copies the shadow registers into its working registers only while the count sits at zero, so every triangle runs start to finish on one consistent set of values. Each channel also has a sticky match flag, which the timer sets when the count meets that channel's threshold and which software clears by writing a one.

Register port (`cfg_sel`): 0 = period shadow, 1 = channel A threshold shadow, 2 = channel B threshold shadow, 3 = control, 4 = flag clear (bit 0 clears A, bit 1 clears B). Control word: bit 0 = peak source (0 period register, 1 channel A threshold), bits 2:1 = channel A drive, bits 4:3 = channel B drive, bits 7:5 = tick select. Drive codes: 0 = pin held low, 1 = toggle at the peak, 2 = direct, 3 = inverted. Tick select: 1 = /1, 2 = /8, 3 = /64, 4 = /256, 5 = /1024, 0 and 6 to 7 = stopped.

Top module: `cpwm_timer`

## Requirements
- R1: After reset both pins are low, both match flags are clear, the count is zero and rising, the tick select is 0 (stopped), and every drive code is 0.
- R2: On each tick the count steps by one, going up from 0 to the peak and then down to 0. The peak and zero each last exactly one tick, so a full triangle lasts 2×peak ticks.
- R3: Control bit 0 picks the peak: 0 takes the period register, 1 takes channel A's working threshold.
- R4: Tick select codes 1 to 5 give one tick every 1, 8, 64, 256 or 1024 clocks. Codes 0, 6 and 7 freeze the count.
- R5: With drive code 2, a pin is high while the count is below its threshold. At count equal to the threshold it is low while rising and high while falling. Drive code 3 gives the complement.
- R6: With drive code 2, a threshold of 0 holds the pin low and a threshold at or above the peak holds it high. Drive code 3 gives the opposite levels.
- R7: With drive code 1 on channel A and the peak taken from channel A, pin A flips once on each tick that leaves the peak, giving a 50% square wave of period 4×peak ticks. Drive code 1 in any other case holds the pin low.
- R8: Writes to the period and threshold registers reach the working registers only on clocks where the count is zero. A write and a copy in the same clock copy the old shadow value.
- R9: A match flag sets on a tick whose current count equals that channel's working threshold, and stays set until a flag-clear write with a one in its bit. When a set and a clear fall in the same clock, the set wins.
- R10: A peak value below 3 is treated as 3.
- R11: Drive code 0 holds a pin low whatever the count and threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| pwm_a | output | 1 | Channel A PWM pin |
| pwm_b | output | 1 | Channel B PWM pin |
| match_a | output | 1 | Channel A sticky match flag |
| match_b | output | 1 | Channel B sticky match flag |

## Verification
Two pairs of events can land on the same clock.

- **Flag set and flag clear.** The bench holds a flag-clear write on every clock while the timer runs at full speed, so a clear is present on each tick where the count meets a threshold. The reference model requires the flag to read set after that clock.
- **Shadow write and copy.** The bench writes thresholds while the count may be at zero. The model requires the working value to take the old shadow value on that clock and the new one from the next.

The bench compares both pins and both flags with its behavioural model on every clock. Edge-spacing and level-count checks measured at the pins confirm the period, the prescale, the toggle rate and the extreme thresholds.

// File: rtl/cpwm_timer.sv
module cpwm_timer #(
  parameter int W       = 16,
  parameter int AW      = 3,
  parameter int PW      = 10,
  parameter int MIN_TOP = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_sel,
  input  logic [W-1:0]  cfg_wdata,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          match_a,
  output logic          match_b
);
  localparam logic [AW-1:0] SEL_TOP  = AW'(0);
  localparam logic [AW-1:0] SEL_CMPA = AW'(1);
  localparam logic [AW-1:0] SEL_CMPB = AW'(2);
  localparam logic [AW-1:0] SEL_CTRL = AW'(3);
  localparam logic [AW-1:0] SEL_CLR  = AW'(4);
  localparam logic [W-1:0]  TOP_FLOOR = W'(MIN_TOP);

  logic [W-1:0]  shd_top, shd_a, shd_b;
  logic [W-1:0]  wrk_top, wrk_a, wrk_b;
  logic [W-1:0]  cnt;
  logic          rising, tog;
  logic          peak_from_a;
  logic [1:0]    drv_a, drv_b;
  logic [2:0]    tsel;
  logic [PW-1:0] pc, lim;
  logic          run, tick;
  logic [W-1:0]  raw_top, top;
  logic          at_bot, at_peak;
  logic          clr_a, clr_b;

  always_comb begin
    run = 1'b1;
    case (tsel)
      3'd1:    lim = PW'(0);
      3'd2:    lim = PW'(7);
      3'd3:    lim = PW'(63);
      3'd4:    lim = PW'(255);
      3'd5:    lim = PW'(1023);
      default: begin lim = '0; run = 1'b0; end
    endcase
  end

  assign tick    = run && (pc >= lim);
  assign raw_top = peak_from_a ? wrk_a : wrk_top;
  assign top     = (raw_top < TOP_FLOOR) ? TOP_FLOOR : raw_top;
  assign at_bot  = (cnt == '0);
  assign at_peak = rising && (cnt >= top);
  assign clr_a   = cfg_we && (cfg_sel == SEL_CLR) && cfg_wdata[0];
  assign clr_b   = cfg_we && (cfg_sel == SEL_CLR) && cfg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else if (!run || tick) pc <= '0;
    else pc <= pc + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rising <= 1'b1;
    end else if (tick) begin
      if (rising) begin
        if (at_peak) begin
          cnt    <= cnt - W'(1);
          rising <= 1'b0;
        end else begin
          cnt <= cnt + W'(1);
        end
      end else begin
        cnt <= cnt - W'(1);
        if (cnt == W'(1)) rising <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_top     <= '1;
      shd_a       <= '0;
      shd_b       <= '0;
      peak_from_a <= 1'b0;
      drv_a       <= '0;
      drv_b       <= '0;
      tsel        <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_TOP:  shd_top <= cfg_wdata;
        SEL_CMPA: shd_a   <= cfg_wdata;
        SEL_CMPB: shd_b   <= cfg_wdata;
        SEL_CTRL: begin
          peak_from_a <= cfg_wdata[0];
          drv_a       <= cfg_wdata[2:1];
          drv_b       <= cfg_wdata[4:3];
          tsel        <= cfg_wdata[7:5];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrk_top <= '1;
      wrk_a   <= '0;
      wrk_b   <= '0;
    end else if (at_bot) begin
      wrk_top <= shd_top;
      wrk_a   <= shd_a;
      wrk_b   <= shd_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_a <= 1'b0;
      match_b <= 1'b0;
      tog     <= 1'b0;
    end else begin
      match_a <= (match_a && !clr_a) || (tick && cnt == wrk_a);
      match_b <= (match_b && !clr_b) || (tick && cnt == wrk_b);
      if (tick && at_peak) tog <= ~tog;
    end
  end

  function automatic logic level(input logic [W-1:0] c, input logic [W-1:0] t,
                                 input logic [W-1:0] v, input logic up);
    if (v == '0) return 1'b0;
    if (v >= t)  return 1'b1;
    return (c < v) || ((c == v) && !up);
  endfunction

  function automatic logic drive(input logic [1:0] m, input logic l, input logic t);
    case (m)
      2'd1:    return t;
      2'd2:    return l;
      2'd3:    return !l;
      default: return 1'b0;
    endcase
  endfunction

  assign pwm_a = drive(drv_a, level(cnt, top, wrk_a, rising), tog && peak_from_a);
  assign pwm_b = drive(drv_b, level(cnt, top, wrk_b, rising), 1'b0);

  assert_peak_turn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_peak) |=> (!rising && cnt == $past(cnt) - W'(1)));

  assert_bottom_turn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rising && cnt == W'(1)) |=> (rising && at_bot));

  assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (cnt == $past(cnt)));

  assert_shadow_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_bot) |=> ($stable(wrk_a) && $stable(wrk_b) && $stable(wrk_top)));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a && !clr_a) |=> match_a);

  assert_peak_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rising && cnt < TOP_FLOOR) |=> (rising && cnt == $past(cnt) + W'(1)));
endmodule

// File: tb/cpwm_timer_tb_top.sv
`timescale 1ns/1ps
module cpwm_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic pwm_a, pwm_b, match_a, match_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit started = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  cpwm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .match_a(match_a), .match_b(match_b));

  int m_stop, m_sa, m_sb, m_wtop, m_wa, m_wb, m_cnt, m_pc;
  int m_da, m_db, m_ts;
  bit m_up, m_tog, m_ma, m_mb, m_psrc;

  function automatic int lim_of(int s);
    case (s)
      1: return 0;
      2: return 7;
      3: return 63;
      4: return 255;
      5: return 1023;
      default: return -1;
    endcase
  endfunction

  function automatic int peak();
    int r = m_psrc ? m_wa : m_wtop;
    return (r < 3) ? 3 : r;
  endfunction

  function automatic bit exp_pin(int drv, int thr, bit tgl);
    int t = peak();
    bit l;
    if (thr == 0) l = 0;
    else if (thr >= t) l = 1;
    else l = (m_cnt < thr) || (m_cnt == thr && !m_up);
    case (drv)
      1: return tgl;
      2: return l;
      3: return !l;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int l, t, n_cnt, n_pc;
    bit tk, n_up, n_ma, n_mb, n_tog, ca, cb;
    if (!rst_n) begin
      m_stop = 65535; m_sa = 0; m_sb = 0; m_wtop = 65535; m_wa = 0; m_wb = 0;
      m_cnt = 0; m_pc = 0; m_da = 0; m_db = 0; m_ts = 0;
      m_up = 1; m_tog = 0; m_ma = 0; m_mb = 0; m_psrc = 0;
      started = 1'b1;
    end else begin
      l = lim_of(m_ts);
      tk = (l >= 0) && (m_pc >= l);
      t = peak();
      n_cnt = m_cnt; n_up = m_up;
      if (tk) begin
        if (m_up) begin
          if (m_cnt >= t) begin n_cnt = m_cnt - 1; n_up = 0; end
          else n_cnt = m_cnt + 1;
        end else begin
          n_cnt = m_cnt - 1;
          if (m_cnt == 1) n_up = 1;
        end
      end
      ca = cfg_we && cfg_sel == 4 && cfg_wdata[0];
      cb = cfg_we && cfg_sel == 4 && cfg_wdata[1];
      n_ma = (m_ma && !ca) || (tk && m_cnt == m_wa);
      n_mb = (m_mb && !cb) || (tk && m_cnt == m_wb);
      n_tog = m_tog ^ (tk && m_up && m_cnt >= t);
      n_pc = (l < 0 || tk) ? 0 : m_pc + 1;
      if (m_cnt == 0) begin m_wtop = m_stop; m_wa = m_sa; m_wb = m_sb; end
      if (cfg_we) begin
        case (cfg_sel)
          0: m_stop = cfg_wdata;
          1: m_sa = cfg_wdata;
          2: m_sb = cfg_wdata;
          3: begin
            m_psrc = cfg_wdata[0]; m_da = cfg_wdata[2:1];
            m_db = cfg_wdata[4:3]; m_ts = cfg_wdata[7:5];
          end
          default: ;
        endcase
      end
      m_cnt = n_cnt; m_up = n_up; m_ma = n_ma; m_mb = n_mb;
      m_tog = n_tog; m_pc = n_pc;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && started && !done) begin
      chk(cur_req, "pwm_a", pwm_a, exp_pin(m_da, m_wa, m_tog && m_psrc));
      chk(cur_req, "pwm_b", pwm_b, exp_pin(m_db, m_wb, 1'b0));
      chk(cur_req, "match_a", match_a, m_ma);
      chk(cur_req, "match_b", match_b, m_mb);
    end
  end

  task automatic wr(int sel, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int ctl(int src, int da, int db, int ts);
    return src | (da << 1) | (db << 3) | (ts << 5);
  endfunction

  task automatic gap(bit ch, int limit, output int g);
    int n = 0;
    int first = -1;
    bit prev = ch ? pwm_b : pwm_a;
    bit cur;
    g = -1;
    while (n < limit) begin
      @(negedge clk);
      n++;
      cur = ch ? pwm_b : pwm_a;
      if (cur && !prev) begin
        if (first < 0) first = n;
        else begin g = n - first; return; end
      end
      prev = cur;
    end
  endtask

  task automatic count_high(bit ch, int len, output int h);
    h = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (ch ? pwm_b : pwm_a) h++;
    end
  endtask

  initial begin
    int g, h;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    chk("R1", "reset pwm_a", pwm_a, 0);
    chk("R1", "reset pwm_b", pwm_b, 0);
    chk("R1", "reset match_a", match_a, 0);
    chk("R1", "reset match_b", match_b, 0);
    repeat (10) @(negedge clk);

    cur_req = "R4";
    wr(0, 10); wr(1, 4); wr(2, 7);
    wr(3, ctl(0, 2, 3, 0));
    repeat (20) @(negedge clk);
    chk("R4", "stopped match_a", match_a, 0);

    cur_req = "R5";
    wr(3, ctl(0, 2, 3, 1));
    repeat (50) @(negedge clk);
    gap(0, 100, g);
    chk("R2", "triangle period /1", g, 20);
    gap(1, 100, g);
    chk("R5", "inverted channel period", g, 20);
    count_high(0, 40, h);
    chk("R5", "direct high clocks per two periods", h, 16);

    cur_req = "R4";
    wr(3, ctl(0, 2, 3, 2));
    repeat (200) @(negedge clk);
    gap(0, 600, g);
    chk("R4", "triangle period /8", g, 160);
    wr(3, ctl(0, 2, 3, 6));
    repeat (30) @(negedge clk);
    chk("R4", "code 6 freezes pin", pwm_a, m_da == 2 ? exp_pin(2, m_wa, 0) : 0);

    cur_req = "R8";
    wr(3, ctl(0, 2, 3, 1));
    for (int k = 0; k < 6; k++) begin
      wr(1, 2 + k); wr(2, 8 - k);
      repeat (3 + k) @(negedge clk);
    end
    repeat (40) @(negedge clk);

    cur_req = "R6";
    wr(1, 0); wr(2, 10);
    repeat (45) @(negedge clk);
    count_high(0, 40, h);
    chk("R6", "direct threshold 0 high clocks", h, 0);
    count_high(1, 40, h);
    chk("R6", "inverted threshold at peak high clocks", h, 0);
    wr(3, ctl(0, 3, 2, 1));
    repeat (2) @(negedge clk);
    count_high(0, 40, h);
    chk("R6", "inverted threshold 0 high clocks", h, 40);
    count_high(1, 40, h);
    chk("R6", "direct threshold at peak high clocks", h, 40);

    cur_req = "R11";
    wr(3, ctl(0, 0, 0, 1));
    count_high(0, 40, h);
    chk("R11", "drive 0 pin A high clocks", h, 0);
    count_high(1, 40, h);
    chk("R11", "drive 0 pin B high clocks", h, 0);

    cur_req = "R7";
    wr(3, ctl(0, 1, 1, 1));
    count_high(0, 40, h);
    chk("R7", "toggle with period source held low", h, 0);
    cur_req = "R3";
    wr(1, 6);
    wr(3, ctl(1, 1, 2, 1));
    repeat (60) @(negedge clk);
    gap(0, 100, g);
    chk("R7", "toggle square period", g, 24);
    count_high(0, 48, h);
    chk("R7", "toggle duty", h, 24);
    wr(2, 2);
    repeat (30) @(negedge clk);
    gap(1, 100, g);
    chk("R3", "peak from channel A period", g, 12);

    cur_req = "R10";
    wr(0, 1); wr(1, 1); wr(2, 2);
    wr(3, ctl(0, 2, 2, 1));
    repeat (30) @(negedge clk);
    gap(0, 60, g);
    chk("R10", "floored peak period", g, 6);

    cur_req = "R9";
    wr(3, ctl(0, 2, 2, 0));
    wr(4, 3);
    @(negedge clk);
    chk("R9", "flag A after clear", match_a, 0);
    chk("R9", "flag B after clear", match_b, 0);
    wr(0, 9); wr(1, 4); wr(2, 5);
    wr(3, ctl(0, 2, 2, 1));
    repeat (40) @(negedge clk);
    chk("R9", "flag A set by match", match_a, 1);
    wr(4, 2);
    @(negedge clk);
    chk("R9", "flag A kept by clear of B only", match_a, 1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 16'd3;
    repeat (40) @(negedge clk);
    cfg_we = 1'b0;
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired during %s actual 1 expected 0", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule